// File: doc/BRIEF.md
# Headed Watermark Serial Generator

This block places a fixed ownership mark in front of a core's serial test response on one shared test output pin. The mark is a 20-bit word that was shuffled by a fixed pseudorandom permutation before it was built in. It is formed from constant logic levels, some of which pass through inverter pairs, so that it sits in the netlist as ordinary gates rather than as a stored table.

While the test-mode input is low, the output and the header flag stay at 0. On the first clock edge that samples test mode high, the word is loaded into a parallel-in serial-out register. The word is then sent most significant bit first, one bit per clock, for exactly 20 cycles. During those cycles the core's response bit is ignored.

After the last mark bit, the output follows the response input directly until test mode is dropped. Dropping test mode at any point returns the block to idle. Raising it again replays the whole header from the first bit.

Top module: `hdr_mark_serializer`

## Requirements
- R1: While rst_n is low, and in the cycle after it is released with test_mode low, test_so and mark_active are 0.
- R2: After any clock edge that samples test_mode low, test_so and mark_active are 0 until the next edge.
- R3: The first edge that samples test_mode high from idle starts the header. The first header cycle shows bit 19 of the mark word on test_so.
- R4: The mark word defaults to 20'hB3A5C. It is sent MSB first (bit 19 down to bit 0), one bit per clock cycle.
- R5: mark_active is 1 in exactly the 20 header cycles and 0 in all other cycles.
- R6: After the 20th header cycle, while test_mode stays high, test_so equals scan_resp_in in the same cycle.
- R7: During the header, scan_resp_in has no effect on test_so and is not stored. After the header, the output shows only the current response bit.
- R8: Dropping test_mode during the header returns the block to idle. Raising it again restarts from bit 19.
- R9: Dropping test_mode during the response phase returns the block to idle. Raising it again sends the full 20-bit header again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode | input | 1 | Test-mode enable |
| scan_resp_in | input | 1 | Core serial test response |
| test_so | output | 1 | Shared serial test output |
| mark_active | output | 1 | High during the mark header |

## Verification
The response input is driven in three ways:
- Held at 0 under the first header. This shows whether the mark bits come from the constant.
- Toggled every cycle under a later header. This shows whether a response bit leaks into the header or is stored for later.
- Driven by a pseudorandom stream in the response phase. This separates true pass-through from a delayed copy.

Test mode is dropped at three points: inside the header, inside the response phase, and at idle. Each drop is followed by a reassertion, which tells a full restart apart from a resumed count.

// File: rtl/hms_pkg.sv
package hms_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HEAD = 2'd1,
        PH_PASS = 2'd2
    } phase_e;
endpackage

// File: rtl/hms_mark_const.sv
module hms_mark_const #(
    parameter int            W       = 20,
    parameter logic [W-1:0]  PATTERN = 20'hB3A5C
) (
    input  logic         enable,
    output logic [W-1:0] word
);
    logic [W-1:0] raw;

    // Even bits are plain tie-offs; odd bits pass through an inverter pair.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if ((i % 2) == 0) begin : g_tie
            assign raw[i] = PATTERN[i];
        end else begin : g_inv
            logic inv_n;
            assign inv_n  = ~PATTERN[i];
            assign raw[i] = ~inv_n;
        end
    end

    // The word is presented only while the load is requested.
    assign word = enable ? raw : '0;
endmodule

// File: rtl/hms_piso.sv
module hms_piso #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         msb
);
    typedef struct packed {
        logic [W-1:0] sr;
    } piso_t;

    piso_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sr = din;
        end else if (shift) begin
            st_d.sr = {st_q.sr[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign msb = st_q.sr[W-1];

    assert_shift_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (st_q.sr[W-1] == $past(st_q.sr[W-2])));
endmodule

// File: rtl/hms_phase_ctrl.sv
module hms_phase_ctrl
    import hms_pkg::*;
#(
    parameter int W = 20
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   test_mode,
    output phase_e phase,
    output logic   load,
    output logic   shift
);
    localparam int              CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        load  = 1'b0;
        shift = 1'b0;
        if (!test_mode) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
        end else begin
            unique case (st_q.ph)
                PH_IDLE: begin
                    load     = 1'b1;
                    st_d.ph  = PH_HEAD;
                    st_d.cnt = '0;
                end
                PH_HEAD: begin
                    shift = 1'b1;
                    if (st_q.cnt == LAST) begin
                        st_d.ph  = PH_PASS;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: st_d.ph = PH_PASS;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.ph;

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_HEAD) |-> (st_q.cnt <= LAST));
    assert_head_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_HEAD && test_mode && st_q.cnt == LAST) |=> (st_q.ph == PH_PASS));
    assert_drop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> (st_q.ph == PH_IDLE));
endmodule

// File: rtl/hdr_mark_serializer.sv
module hdr_mark_serializer
    import hms_pkg::*;
#(
    parameter int            MARK_W       = 20,
    parameter logic [MARK_W-1:0] MARK_PATTERN = 20'hB3A5C
) (
    input  logic clk,
    input  logic rst_n,
    input  logic test_mode,
    input  logic scan_resp_in,
    output logic test_so,
    output logic mark_active
);
    phase_e            phase;
    logic              load;
    logic              shift;
    logic [MARK_W-1:0] word;
    logic              mark_bit;

    hms_phase_ctrl #(.W(MARK_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .phase     (phase),
        .load      (load),
        .shift     (shift)
    );

    hms_mark_const #(.W(MARK_W), .PATTERN(MARK_PATTERN)) u_const (
        .enable (load),
        .word   (word)
    );

    hms_piso #(.W(MARK_W)) u_piso (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (shift),
        .din   (word),
        .msb   (mark_bit)
    );

    always_comb begin
        unique case (phase)
            PH_HEAD: test_so = mark_bit;
            PH_PASS: test_so = scan_resp_in;
            default: test_so = 1'b0;
        endcase
    end

    assign mark_active = (phase == PH_HEAD);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> (!test_so && !mark_active));
    assert_first_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (test_so == MARK_PATTERN[MARK_W-1]));
    assert_flag_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mark_active) |-> $past(test_mode));
endmodule

// File: tb/hdr_mark_serializer_tb_top.sv
`timescale 1ns/1ps
module hdr_mark_serializer_tb_top;
    localparam logic [19:0] PAT = 20'hB3A5C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_mode = 1'b0;
    logic scan_resp_in = 1'b0;
    logic test_so;
    logic mark_active;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    string scen = "R1";
    logic [15:0] lfsr = 16'hACE1;

    // Reference model: 0 idle, 1 header, 2 response
    int m_ph = 0;
    int m_idx = 0;

    always #2.5 clk = ~clk;

    hdr_mark_serializer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .test_mode    (test_mode),
        .scan_resp_in (scan_resp_in),
        .test_so      (test_so),
        .mark_active  (mark_active)
    );

    always @(posedge clk) begin
        if (!rst_n || !test_mode) begin
            m_ph = 0;
            m_idx = 0;
        end else if (m_ph == 0) begin
            m_ph = 1;
            m_idx = 0;
        end else if (m_ph == 1) begin
            if (m_idx == 19) m_ph = 2;
            else m_idx = m_idx + 1;
        end
    end

    always @(negedge clk) begin
        logic exp_o;
        logic exp_f;
        if (!done) begin
            exp_o = (m_ph == 1) ? PAT[19 - m_idx] : (m_ph == 2) ? scan_resp_in : 1'b0;
            exp_f = (m_ph == 1);
            n_cmp++;
            if (test_so !== exp_o) begin
                n_bad++;
                $display("FAIL %s test_so: actual %b expected %b (phase %0d idx %0d)",
                         scen, test_so, exp_o, m_ph, m_idx);
            end
            n_cmp++;
            if (mark_active !== exp_f) begin
                n_bad++;
                $display("FAIL R5 mark_active: actual %b expected %b", mark_active, exp_f);
            end
        end
    end

    // mode: 0 hold low, 1 toggle, 2 pseudorandom
    task automatic run(input int n, input logic tm, input int mode);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #1;
            test_mode = tm;
            if (mode == 0) scan_resp_in = 1'b0;
            else if (mode == 1) scan_resp_in = ~scan_resp_in;
            else begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                scan_resp_in = lfsr[0];
            end
        end
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        scen = "R1";
        run(3, 1'b0, 1);
        rst_n = 1'b1;
        scen = "R2";
        run(5, 1'b0, 2);
        scen = "R3/R4";
        run(20, 1'b1, 0);
        scen = "R6";
        run(30, 1'b1, 2);
        scen = "R9";
        run(4, 1'b0, 2);
        scen = "R7";
        run(20, 1'b1, 1);
        scen = "R6";
        run(12, 1'b1, 2);
        scen = "R8";
        run(2, 1'b0, 0);
        run(8, 1'b1, 1);
        run(2, 1'b0, 1);
        run(30, 1'b1, 2);
        scen = "R2";
        run(4, 1'b0, 2);
        @(negedge clk);
        finish_up();
    end

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end
endmodule